// File: doc/BRIEF.md
# Signed Array Multiplier (Baugh-Wooley Form)

This block multiplies two two's-complement operands and returns their full-width signed product within the same cycle. It has no clock, reset or handshake. Operands go in and the product comes out through pure logic, so a parent pipeline can place registers around it wherever it wants.

The partial-product matrix is built so that no row needs sign extension. Any product bit that pairs exactly one operand sign bit with a non-sign bit is complemented. The bit that pairs the two sign bits stays a plain AND. Two constant ones are injected, one at weight `WIDTH` and one at weight `2*WIDTH-1`. The rows then go through a regular carry-save array of half and full adders, one stage per row after the first. A ripple-carry adder resolves the final sum and carry vectors. Any carry out of the top product bit is dropped.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of `WIDTH`-bit two's-complement operands, `product_o` equals their exact `2*WIDTH`-bit two's-complement product (65536 pairs at the default `WIDTH` of 8).
- R2: When either operand is zero, `product_o` is zero.
- R3: The most negative operand times itself gives `2^(2*WIDTH-2)` (0x4000 at the default width), a positive value with bit `2*WIDTH-1` clear.
- R4: Multiplying by +1 returns the other operand sign-extended to `2*WIDTH` bits. Multiplying by -1 (all ones) returns its two's-complement negation, and the most negative operand times -1 gives `+2^(WIDTH-1)` (0x0080).
- R5: With both operands nonzero, bit `2*WIDTH-1` of `product_o` is 1 when the operand sign bits (bit `WIDTH-1`) differ, and 0 when they match.
- R6: Swapping the two operands does not change `product_o`.
- R7: `product_o` follows a change of the operands with no clock edge, and the value seen after the operands change depends only on the new operands.
- R8: Operand pairs whose product depends mainly on the complemented mixed-sign bits give the exact product. Examples are 127 x -128 = -16256 (0xC080), -1 x -1 = 1, and -128 x 1 = 0xFF80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Multiplicand, two's complement |
| b_i | input | WIDTH | Multiplier, two's complement |
| product_o | output | 2*WIDTH | Signed product, two's complement |

## Verification
An exhaustive sweep of every operand pair compares the output with an integer multiply. This sweep is the only way to expose a wrong inversion mask or a misplaced constant one that affects just a few columns. Directed pairs back it up. Zero operands isolate the constant injections, since with all other bits zero only the injected ones and the complemented bits must cancel. Plus and minus one, together with the most negative value, stress the sign-bit row and column where the complemented bits sit. Swapped operands and back-to-back operand changes with no clock edge show that the array is symmetric and holds no state.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  // A partial-product bit is complemented when exactly one index is the sign position.
  function automatic bit pp_is_inverted(input int i, input int j, input int n);
    return (i == n - 1) != (j == n - 1);
  endfunction

  // Correction ones at weights n and 2n-1.
  function automatic logic [127:0] bw_const_ones(input int n);
    logic [127:0] v;
    v = '0;
    v[n] = 1'b1;
    v[2*n-1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/bw_adder_cells.sv
module bw_half_adder (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);
  assign sum_o   = a_i ^ b_i;
  assign carry_o = a_i & b_i;
endmodule

module bw_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic carry_o
);
  assign sum_o   = a_i ^ b_i ^ cin_i;
  assign carry_o = (a_i & b_i) | (b_i & cin_i) | (a_i & cin_i);
endmodule

// File: rtl/bw_pp_gen.sv
module bw_pp_gen
  import bw_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]            a_i,
  input  logic [WIDTH-1:0]            b_i,
  output logic [WIDTH-1:0][WIDTH-1:0] rows_o   // rows_o[j][i] has weight i+j
);
  for (genvar j = 0; j < WIDTH; j++) begin : g_row
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
      if (pp_is_inverted(i, j, WIDTH)) begin : g_inv
        assign rows_o[j][i] = ~(a_i[i] & b_i[j]);
      end else begin : g_plain
        assign rows_o[j][i] = a_i[i] & b_i[j];
      end
    end
  end
endmodule

// File: rtl/bw_csa_stage.sv
// One array stage: folds one shifted row into the running sum/carry vectors.
module bw_csa_stage #(
  parameter int WIDTH  = 8,
  parameter int ROW_LO = 1,
  localparam int PW    = 2 * WIDTH,
  localparam int ROW_HI = ROW_LO + WIDTH - 1
) (
  input  logic [PW-1:0]    sum_i,
  input  logic [PW-1:0]    carry_i,
  input  logic [WIDTH-1:0] row_i,
  output logic [PW-1:0]    sum_o,
  output logic [PW-1:0]    carry_o
);
  assign carry_o[0] = 1'b0;

  for (genvar w = 0; w < PW; w++) begin : g_col
    localparam bit IN_ROW = (w >= ROW_LO) && (w <= ROW_HI);
    if (w == PW - 1) begin : g_top
      // carry beyond the top product bit is discarded
      if (IN_ROW) begin : g_r
        assign sum_o[w] = sum_i[w] ^ carry_i[w] ^ row_i[w-ROW_LO];
      end else begin : g_n
        assign sum_o[w] = sum_i[w] ^ carry_i[w];
      end
    end else if (IN_ROW) begin : g_fa
      bw_full_adder u_fa (
        .a_i    (sum_i[w]),
        .b_i    (carry_i[w]),
        .cin_i  (row_i[w-ROW_LO]),
        .sum_o  (sum_o[w]),
        .carry_o(carry_o[w+1])
      );
    end else begin : g_ha
      bw_half_adder u_ha (
        .a_i    (sum_i[w]),
        .b_i    (carry_i[w]),
        .sum_o  (sum_o[w]),
        .carry_o(carry_o[w+1])
      );
    end
  end
endmodule

// File: rtl/bw_ripple_adder.sv
module bw_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] carry;

  bw_half_adder u_lsb (
    .a_i    (a_i[0]),
    .b_i    (b_i[0]),
    .sum_o  (sum_o[0]),
    .carry_o(carry[0])
  );

  for (genvar k = 1; k < WIDTH - 1; k++) begin : g_bit
    bw_full_adder u_fa (
      .a_i    (a_i[k]),
      .b_i    (b_i[k]),
      .cin_i  (carry[k-1]),
      .sum_o  (sum_o[k]),
      .carry_o(carry[k])
    );
  end

  assign sum_o[WIDTH-1] = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ carry[WIDTH-2];
  assign carry[WIDTH-1] = 1'b0;
endmodule

// File: rtl/bw_signed_mult.sv
module bw_signed_mult
  import bw_mult_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW   = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [PW-1:0]    product_o
);
  localparam logic [127:0] CONST_ALL = bw_const_ones(WIDTH);
  localparam logic [PW-1:0] CONST_ONES = CONST_ALL[PW-1:0];

  logic [WIDTH-1:0][WIDTH-1:0] rows;
  logic [WIDTH-1:0][PW-1:0]    sum_chain;
  logic [WIDTH-1:0][PW-1:0]    carry_chain;

  bw_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .rows_o(rows)
  );

  // Row 0 seeds the sum vector; the correction ones seed the carry vector.
  assign sum_chain[0]   = {{WIDTH{1'b0}}, rows[0]};
  assign carry_chain[0] = CONST_ONES;

  for (genvar k = 1; k < WIDTH; k++) begin : g_stage
    bw_csa_stage #(.WIDTH(WIDTH), .ROW_LO(k)) u_stage (
      .sum_i  (sum_chain[k-1]),
      .carry_i(carry_chain[k-1]),
      .row_i  (rows[k]),
      .sum_o  (sum_chain[k]),
      .carry_o(carry_chain[k])
    );
  end

  bw_ripple_adder #(.WIDTH(PW)) u_cpa (
    .a_i  (sum_chain[WIDTH-1]),
    .b_i  (carry_chain[WIDTH-1]),
    .sum_o(product_o)
  );
endmodule

// File: rtl/bw_signed_mult_chk.sv
module bw_signed_mult_chk #(
  parameter int WIDTH = 8,
  localparam int PW   = 2 * WIDTH
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [PW-1:0]    product_o
);
  localparam logic [WIDTH-1:0] MIN_OP = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE_OP = {{(WIDTH-1){1'b0}}, 1'b1};

  logic signed [PW-1:0] exp_p;
  logic [PW-1:0]        min_sq;

  always_comb begin
    exp_p  = $signed(a_i) * $signed(b_i);
    min_sq = '0;
    min_sq[PW-2] = 1'b1;

    assert_exact_product_R1: assert (product_o == exp_p)
      else $error("R1 product mismatch");

    if (a_i == '0 || b_i == '0)
      assert_zero_operand_R2: assert (product_o == '0)
        else $error("R2 nonzero product for zero operand");

    if (a_i == MIN_OP && b_i == MIN_OP)
      assert_min_square_R3: assert (product_o == min_sq)
        else $error("R3 min square wrong");

    if (b_i == ONE_OP)
      assert_unit_mult_R4: assert (product_o == {{WIDTH{a_i[WIDTH-1]}}, a_i})
        else $error("R4 unit multiply wrong");

    if (a_i != '0 && b_i != '0)
      assert_sign_R5: assert (product_o[PW-1] == (a_i[WIDTH-1] ^ b_i[WIDTH-1]))
        else $error("R5 sign wrong");
  end
endmodule

bind bw_signed_mult bw_signed_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .product_o(product_o)
);

// File: tb/bw_signed_mult_tb.sv
`timescale 1ns/1ps
module bw_signed_mult_tb;
  localparam int W  = 8;
  localparam int PW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bw_signed_mult #(.WIDTH(W)) u_dut (.a_i(a), .b_i(b), .product_o(p));

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d act=%h exp=%h", req, $signed(a), $signed(b), act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input int x, input int y);
    int r;
    r = x * y;
    return r[PW-1:0];
  endfunction

  task automatic drive_check(input string req, input int x, input int y);
    @(negedge clk);
    a = x[W-1:0];
    b = y[W-1:0];
    #1;
    check(req, p, ref_mul(x, y));
  endtask

  initial begin
    logic [PW-1:0] p_ab;
    a = '0;
    b = '0;
    #1;
    check("R2_init", p, '0);

    // R2 zero operands
    drive_check("R2", 0, -128);
    drive_check("R2", 127, 0);
    drive_check("R2", 0, -1);
    // R3 most negative squared
    drive_check("R3", -128, -128);
    check("R3_val", p, 16'h4000);
    // R4 unit and minus one
    drive_check("R4", 93, 1);
    drive_check("R4", -77, 1);
    drive_check("R4", 45, -1);
    drive_check("R4", -128, -1);
    check("R4_val", p, 16'h0080);
    // R8 mixed-sign complemented bits
    drive_check("R8", 127, -128);
    check("R8_val", p, 16'hC080);
    drive_check("R8", -1, -1);
    check("R8_one", p, 16'h0001);
    drive_check("R8", -128, 1);
    check("R8_ext", p, 16'hFF80);
    drive_check("R8", 127, 127);
    // R5 sign
    drive_check("R5", -3, 5);
    check("R5_neg", {15'd0, p[15]}, 16'd1);
    drive_check("R5", -3, -5);
    check("R5_pos", {15'd0, p[15]}, 16'd0);

    // R7 no clock edge between operand changes
    @(negedge clk);
    a = 8'd12; b = 8'd11; #0.5;
    check("R7", p, ref_mul(12, 11));
    a = 8'hF0; #0.5;
    check("R7", p, ref_mul(-16, 11));
    b = 8'h80; #0.5;
    check("R7", p, ref_mul(-16, -128));

    // R1 exhaustive and R6 swap
    for (int x = -128; x < 128; x++) begin
      for (int y = -128; y < 128; y++) begin
        drive_check("R1", x, y);
      end
    end
    for (int k = 0; k < 64; k++) begin
      int x, y;
      x = (k * 37 + 5) % 256 - 128;
      y = (k * 91 + 17) % 256 - 128;
      drive_check("R6", x, y);
      p_ab = p;
      drive_check("R6", y, x);
      check("R6_swap", p, p_ab);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule